// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a single-word on-chip request port and an external 512K x 8 asynchronous static RAM. Each accepted request becomes one strobe sequence on the memory pins: a read drives chip select and output enable low and samples the data bus at the end of the access window. A write drives chip select and write enable low while the controller drives the data bus. All timing is counted in clock cycles. Every nanosecond limit is converted into a cycle count by ceiling division by the clock-period parameter, so one RTL body serves any clock rate.

After reset the controller waits out the memory's power-up interval with ready low. While idle, chip select is held high so the memory stays in standby. After every read it inserts a quiet interval so that the memory has released the shared data bus before the controller can drive it again. A write is ended by the rising write-enable edge. Address and write data stay steady through that edge and for at least one further cycle.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted, mem_ce_n, mem_oe_n and mem_we_n are high, and mem_dq_oe, req_ready and rd_valid are low.
- R2: After reset is released, req_ready stays low and mem_ce_n stays high for PU_CYC = ceil(T_PU_NS/CLK_NS) cycles (100 at defaults). req_ready is high after the PU_CYC-th rising edge.
- R3: Whenever req_ready is high, all three strobes are high and mem_dq_oe is low.
- R4: During a read, mem_ce_n=0, mem_oe_n=0, mem_we_n=1 and mem_dq_oe=0, and mem_addr holds the requested address.
- R5: A read lasts RD_CYC = max(ceil(tAA), ceil(tRC)) cycles (2 at defaults). rd_valid is high for exactly one cycle, starting at the RD_CYC-th rising edge after the accepting edge. rd_data at that point carries the bus value sampled at that edge.
- R6: A write drives mem_ce_n=0, mem_we_n=0, mem_oe_n=1 and mem_dq_oe=1 with the request's data on mem_dq_out. mem_addr and mem_dq_out do not change while mem_we_n is low.
- R7: mem_we_n stays low for exactly WR_CYC = max(ceil(tPWE), ceil(tAW), ceil(tSD)) consecutive cycles (1 at defaults). In the cycle after it rises, mem_dq_oe is still high and mem_addr and mem_dq_out are unchanged.
- R8: mem_dq_oe is never high while mem_oe_n is low, and it rises no sooner than HZ_CYC = ceil(tHZOE) cycles (1 at defaults) after mem_oe_n rises. req_ready returns RD_CYC+HZ_CYC cycles after a read is accepted.
- R9: A request is taken only at a rising edge where req_valid and req_ready are both high. req_ready is low in the cycle that follows. Each accepted read produces exactly one rd_valid pulse. A request held while busy is accepted one cycle after req_ready returns.
- R10: A read returns the byte last written to the same address, including addresses 0 and 19'h7FFFF and the data values 8'h00 and 8'hFF.
- R11: A write keeps req_ready low for max(WR_CYC+1, ceil(tWC)) cycles after acceptance (2 at defaults).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller idle and able to accept |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds read result |
| rd_data | output | 8 | Read result |
| mem_addr | output | 19 | Memory address pins |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | 8 | Data to drive on the shared bus |
| mem_dq_oe | output | 1 | Pad driver enable for the shared bus |
| mem_dq_in | input | 8 | Data seen on the shared bus |

## Verification
The memory model returns a poison byte until a read has been held steady for two sampled half-cycles, so a capture taken one edge early is visible as a wrong value. Isolated accesses with a measured return to ready separate the read path length, including turnaround, from the write path length. Back-to-back requests with valid held while busy show whether the hold-off and acceptance edge are correct. Writes to address extremes and the all-zero and all-one bytes, followed by read-back and an overwrite, separate address and data corruption from ordering errors.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    S_PWR,
    S_IDLE,
    S_RD,
    S_RTA,
    S_WR,
    S_WH
  } seq_st_t;

  // ceiling division of a time limit by the clock period; zero stays zero
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
    if (ns == 0) return 0;
    return (ns + per - 1) / per;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int CNT_W = 8,
  parameter int unsigned RST_VAL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_W'(RST_VAL);
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int unsigned RD_CYC = 2,
  parameter int unsigned WR_CYC = 1,
  parameter int unsigned WH_CYC = 1,
  parameter int unsigned HZ_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_last,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture,
  output logic             ready,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             dq_oe
);

  seq_st_t st_q, st_d;
  logic ce_n_d, oe_n_d, we_n_d, dq_oe_d;

  assign ready   = (st_q == S_IDLE);
  assign accept  = ready && req_valid;
  assign capture = (st_q == S_RD) && tmr_last;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      S_PWR:  if (tmr_last) st_d = S_IDLE;
      S_IDLE: if (req_valid) begin
        tmr_load = 1'b1;
        if (req_write) begin
          st_d    = S_WR;
          tmr_val = CNT_W'(WR_CYC);
        end else begin
          st_d    = S_RD;
          tmr_val = CNT_W'(RD_CYC);
        end
      end
      S_RD: if (tmr_last) begin
        st_d     = S_RTA;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(HZ_CYC);
      end
      S_RTA: if (tmr_last) st_d = S_IDLE;
      S_WR: if (tmr_last) begin
        st_d     = S_WH;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(WH_CYC);
      end
      S_WH: if (tmr_last) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  // strobes are registered from the next state so the pins never glitch
  always_comb begin
    ce_n_d  = !((st_d == S_RD) || (st_d == S_WR));
    oe_n_d  = (st_d != S_RD);
    we_n_d  = (st_d != S_WR);
    dq_oe_d = (st_d == S_WR) || (st_d == S_WH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_PWR;
      ce_n  <= 1'b1;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      st_q  <= st_d;
      ce_n  <= ce_n_d;
      oe_n  <= oe_n_d;
      we_n  <= we_n_d;
      dq_oe <= dq_oe_d;
    end
  end

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      dq_out <= '0;
    end else if (accept) begin
      addr   <= req_addr;
      dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (capture) rdata <= dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= capture;
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int unsigned CLK_NS = 10,
  parameter int unsigned T_PU_NS = 1000,
  parameter int unsigned T_AA_NS = 12,
  parameter int unsigned T_RC_NS = 12,
  parameter int unsigned T_PWE_NS = 10,
  parameter int unsigned T_AW_NS = 10,
  parameter int unsigned T_SD_NS = 7,
  parameter int unsigned T_WC_NS = 12,
  parameter int unsigned T_HZOE_NS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned RD_CYC = umax(umax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_RC_NS, CLK_NS)), 1);
  localparam int unsigned WR_CYC = umax(umax(ns2cyc(T_PWE_NS, CLK_NS), ns2cyc(T_AW_NS, CLK_NS)),
                                        umax(ns2cyc(T_SD_NS, CLK_NS), 1));
  localparam int unsigned WC_CYC = ns2cyc(T_WC_NS, CLK_NS);
  localparam int unsigned WH_CYC = (WC_CYC > WR_CYC + 1) ? (WC_CYC - WR_CYC) : 1;
  localparam int unsigned HZ_CYC = umax(ns2cyc(T_HZOE_NS, CLK_NS), 1);
  localparam int unsigned PU_CYC = umax(ns2cyc(T_PU_NS, CLK_NS), 1);
  localparam int unsigned MAX_CYC = umax(umax(PU_CYC, RD_CYC), umax(umax(WR_CYC, WH_CYC), HZ_CYC));
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  logic             tmr_load, tmr_last, accept, capture;
  logic [CNT_W-1:0] tmr_val;

  asram_timer #(.CNT_W(CNT_W), .RST_VAL(PU_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  asram_seq #(
    .CNT_W(CNT_W), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .WH_CYC(WH_CYC), .HZ_CYC(HZ_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .tmr_last  (tmr_last),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .accept    (accept),
    .capture   (capture),
    .ready     (req_ready),
    .ce_n      (mem_ce_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .dq_oe     (mem_dq_oe)
  );

  asram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .dq_in     (mem_dq_in),
    .addr      (mem_addr),
    .dq_out    (mem_dq_out),
    .rdata     (rd_data),
    .rvalid    (rd_valid)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int unsigned HZ_CYC = 1,
  parameter int unsigned PU_CYC = 100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_out
);

  localparam int PU_W = $clog2(PU_CYC + 1) + 1;
  localparam int GAP_W = $clog2(HZ_CYC + 1) + 1;

  logic [PU_W-1:0]  pu_cnt;
  logic [GAP_W-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pu_cnt <= '0;
    else if (pu_cnt < PU_W'(PU_CYC)) pu_cnt <= pu_cnt + 1'b1;
  end

  // cycles since output enable was last seen low, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 gap_cnt <= '1;
    else if (!mem_oe_n)         gap_cnt <= '0;
    else if (gap_cnt != '1)     gap_cnt <= gap_cnt + 1'b1;
  end

  AST_POWERUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_cnt < PU_W'(PU_CYC)) |-> (!req_ready && mem_ce_n)); // R2

  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe)); // R3

  AST_READ_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n && !mem_dq_oe)); // R4

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R5

  AST_WRITE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe)); // R6

  AST_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out))); // R6

  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_out))); // R7

  AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && (gap_cnt >= GAP_W'(HZ_CYC)))); // R8

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R9

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HZ_CYC(HZ_CYC), .PU_CYC(PU_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rd_valid   (rd_valid),
  .mem_ce_n   (mem_ce_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_dq_oe  (mem_dq_oe),
  .mem_addr   (mem_addr),
  .mem_dq_out (mem_dq_out)
);

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;

  localparam int CLK_NS = 10;
  // expected counts worked out by hand from the requirements at CLK_NS = 10
  localparam int PU_EXP = 100; // ceil(1000/10)
  localparam int RD_EXP = 2;   // max(ceil(12/10), ceil(12/10))
  localparam int WE_EXP = 1;   // max(ceil(10/10), ceil(10/10), ceil(7/10))
  localparam int HZ_EXP = 1;   // ceil(6/10)
  localparam int WR_TOT = 2;   // max(WE_EXP+1, ceil(12/10))

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [18:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready, rd_valid;
  logic [7:0]  rd_data;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  model_out = 8'hEE;

  asram_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(model_out)
  );

  always #(CLK_NS/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [7:0] mem_arr [int];
  logic [7:0] ref_arr [int];
  int  rd_age = 0;
  logic [18:0] rd_a;
  bit  pw = 1'b0;
  int  wl = 0;
  logic [18:0] w_a;
  logic [7:0]  w_d;
  bit  w_bad = 1'b0;
  int  oe_gap = 1000;
  bit  prev_dqoe = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      // read side: data only valid after the read has been held for two samples
      if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
        if (rd_age == 0) begin
          check(!mem_dq_oe && mem_we_n, "R4", "read strobes / bus drive", mem_dq_oe, 0);
          rd_age = 1;
          rd_a = mem_addr;
        end else if (mem_addr == rd_a) begin
          rd_age++;
        end else begin
          rd_age = 1;
          rd_a = mem_addr;
        end
      end else begin
        rd_age = 0;
      end
      model_out = (rd_age >= 2) ? (mem_arr.exists(int'(rd_a)) ? mem_arr[int'(rd_a)] : 8'h00) : 8'hEE;

      // write side
      if (!mem_ce_n && !mem_we_n) begin
        if (!pw) begin
          wl = 1; w_a = mem_addr; w_d = mem_dq_out; w_bad = !mem_dq_oe || !mem_oe_n;
        end else begin
          wl++;
          if (mem_addr != w_a || mem_dq_out != w_d || !mem_dq_oe) w_bad = 1'b1;
        end
        pw = 1'b1;
      end else if (pw) begin
        pw = 1'b0;
        mem_arr[int'(w_a)] = w_d;
        check(!w_bad, "R6", "write strobes/address/data steady while low", int'(w_bad), 0);
        check(wl == WE_EXP, "R7", "write-enable low width", wl, WE_EXP);
        check(mem_dq_oe && mem_addr == w_a && mem_dq_out == w_d, "R7",
              "hold after write end", int'(mem_dq_out), int'(w_d));
      end

      // turnaround
      if (!mem_oe_n) oe_gap = 0;
      else if (oe_gap < 1000) oe_gap++;
      if (mem_dq_oe && !prev_dqoe)
        check(oe_gap > HZ_EXP, "R8", "samples between oe release and bus drive", oe_gap, HZ_EXP + 1);
      prev_dqoe = mem_dq_oe;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [7:0] d;
    int         acc;
  } exp_t;
  exp_t exp_q[$];
  bit prev_rv = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid) begin
        if (prev_rv) check(1'b0, "R5", "rd_valid longer than one cycle", 2, 1);
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", "rd_valid without a read", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(rd_data == e.d, "R10", "read data", int'(rd_data), int'(e.d));
          check(cyc - e.acc == RD_EXP, "R5", "read latency in cycles", cyc - e.acc, RD_EXP);
        end
      end
      prev_rv = rd_valid;
    end
  end

  // ---------------- driver ----------------
  task automatic do_req(input bit wr, input logic [18:0] a, input logic [7:0] d, input bit meas);
    int acc;
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    acc = cyc;
    req_valid = 1'b0;
    check(!req_ready, "R9", "ready low after acceptance", int'(req_ready), 0);
    if (wr) begin
      ref_arr[int'(a)] = d;
    end else begin
      exp_t e;
      e.d = ref_arr.exists(int'(a)) ? ref_arr[int'(a)] : 8'h00;
      e.acc = acc;
      exp_q.push_back(e);
    end
    if (meas) begin
      n = 0;
      while (!req_ready) begin
        @(negedge clk);
        n++;
      end
      if (wr) check(n == WR_TOT, "R11", "write cycles until ready", n, WR_TOT);
      else    check(n == RD_EXP + HZ_EXP, "R8", "read cycles until ready", n, RD_EXP + HZ_EXP);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int n;
    bit quiet;
    int a0, a1;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_oe_n && mem_we_n, "R1", "strobes high in reset",
          {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    check(!mem_dq_oe && !req_ready && !rd_valid, "R1", "enables low in reset",
          {mem_dq_oe, req_ready, rd_valid}, 0);

    rst_n = 1'b1;
    n = 0; quiet = 1'b1;
    while (!req_ready) begin
      @(negedge clk);
      n++;
      if (!mem_ce_n) quiet = 1'b0;
      if (n > 1000) break;
    end
    check(n == PU_EXP, "R2", "power-up cycles", n, PU_EXP);
    check(quiet, "R2", "chip select high during power-up", int'(quiet), 1);
    check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R3", "standby when idle",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 14);

    // isolated accesses with measured return to ready
    do_req(1'b1, 19'h00000, 8'hA5, 1'b1);
    do_req(1'b0, 19'h00000, 8'h00, 1'b1);
    do_req(1'b1, 19'h7FFFF, 8'hFF, 1'b1);
    do_req(1'b0, 19'h7FFFF, 8'h00, 1'b1);
    do_req(1'b1, 19'h2AAAA, 8'h00, 1'b1);
    do_req(1'b0, 19'h2AAAA, 8'h00, 1'b1);

    // back-to-back: request held while busy
    for (int i = 0; i < 8; i++)
      do_req(1'b1, 19'(i * 4099 + 17), 8'(i * 37 + 1), 1'b0);
    for (int i = 0; i < 8; i++)
      do_req(1'b0, 19'(i * 4099 + 17), 8'h00, 1'b0);

    // spacing of two held writes
    do_req(1'b1, 19'h12345, 8'h3C, 1'b0);
    a0 = cyc;
    do_req(1'b1, 19'h00000, 8'hC3, 1'b0);
    a1 = cyc;
    check(a1 - a0 == WR_TOT + 1, "R9", "held request accepted after ready", a1 - a0, WR_TOT + 1);
    do_req(1'b0, 19'h00000, 8'h00, 1'b0);
    do_req(1'b0, 19'h12345, 8'h00, 1'b0);

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R9", "one rd_valid per read", exp_q.size(), 0);
    check(req_ready && mem_ce_n, "R3", "standby after traffic", {req_ready, mem_ce_n}, 3);
    done = 1'b1;
    finish_run();
  end

endmodule